// File: doc/BRIEF.md
# Locked-cycle bus arbitration controller

This block sits on the processor side of a shared bus. It decides when the processor hands the bus to an alternate master. It watches an asynchronous bus request and an asynchronous grant acknowledge from that master. It drives a grant line, and it drives an enable that puts the processor's address, data and control buffers into high impedance. The processor reports its locked read-modify-write activity to the block through a lock level and a bus-cycle-end pulse. From these the block works out whether the locked sequence is still in its first read. Once the sequence has moved past that read, requests are held off until the lock drops.

The arbiter has seven numbered states:
- ST_OWN (0): the processor owns the bus.
- ST_GRANT (1): grant is out and the block waits for the acknowledge.
- ST_DRAIN (2): the acknowledge has been seen and the block waits for the strobe to go idle.
- ST_QUIET (3): the strobe was idle on one edge.
- ST_RELEASED (4): the buffers float.
- ST_REGRANT (5): grant is out again while the bus is still released.
- ST_FORCE (6): a one-cycle forced relinquish-and-retry.

The transitions are:
- 0→1: request.
- 0→4: acknowledge with no request.
- 0→6: bus error, halt and request together during the first read.
- 6→1: always, after one cycle.
- 1→2: acknowledge.
- 1→0: the request is withdrawn, or the lock passes its first read.
- 2→3: strobe idle.
- 3→4: strobe idle again.
- 3→2: strobe busy.
- 2/3/4/5→0: the acknowledge is negated.
- 4→5: request.
- 5→4: the request is withdrawn.

Top module: `bus_arb_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to ST_OWN with grant_o, float_o and retry_o all 0.
- R2: Each of breq_i and back_i passes through a two-flop synchroniser. From ST_OWN with no lock, a request applied before edge k gives grant_o = 1 after edge k+2 and not earlier.
- R3: grant_o is 1 in ST_GRANT. It falls at the edge that acts on the synchronised acknowledge, and the arbiter enters ST_DRAIN.
- R4: From ST_DRAIN, float_o rises only after strobe_n_i has been 1 at two consecutive rising edges. A 0 at the edge in between restarts the count.
- R5: In ST_RELEASED, float_o is 1 and grant_o is 0 for as long as the acknowledge stays asserted and no request is present.
- R6: When the synchronised acknowledge goes low, the arbiter returns to ST_OWN. float_o stays 1 for exactly one further cycle and then falls.
- R7: A renewed request in ST_RELEASED moves to ST_REGRANT, with grant_o = 1 and float_o still 1. Withdrawing that request while the acknowledge is held returns to ST_RELEASED, with grant_o = 0 and float_o = 1.
- R8: In ST_OWN, a synchronised acknowledge with no request goes straight to ST_RELEASED. float_o becomes 1 three edges after back_i rises, and grant_o never rises.
- R9: A past-first-read flag is set by a cyc_end_i pulse while rmw_i is 1 and cleared when rmw_i is 0. While rmw_i and the flag are both 1, requests and a lone acknowledge are ignored (grant_o and float_o stay 0). An arbiter already in ST_GRANT falls back to ST_OWN. A request still present when rmw_i drops is granted on the next edge.
- R10: During the first read of a locked sequence (rmw_i = 1, flag clear), a request is granted exactly as in R2.
- R11: In ST_OWN during the first read, berr_i = halt_i = 1 together with the synchronised request enters ST_FORCE. In ST_FORCE, retry_o = 1 and grant_o = 1 for one cycle, then the arbiter is in ST_GRANT. Past the first read, the same inputs give neither retry_o nor grant_o.
- R12: In ST_GRANT, withdrawing the request before any acknowledge returns to ST_OWN and drops grant_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| breq_i | input | 1 | Bus request from the alternate master, asynchronous, active high |
| back_i | input | 1 | Grant acknowledge from the alternate master, asynchronous, active high |
| strobe_n_i | input | 1 | Processor address strobe, synchronous, active low |
| rmw_i | input | 1 | A locked read-modify-write sequence is in progress |
| cyc_end_i | input | 1 | One-cycle pulse when a processor bus cycle terminates |
| berr_i | input | 1 | Bus error, synchronous |
| halt_i | input | 1 | Halt, synchronous |
| grant_o | output | 1 | Bus grant to the alternate master |
| float_o | output | 1 | Puts the processor bus buffers in high impedance |
| retry_o | output | 1 | One-cycle pulse that asks the bus unit to relinquish and retry |

## Verification
The forced relinquish is the hardest situation to reach from the ports. The arbiter must still be in ST_OWN while the locked sequence sits in its first read, and bus error, halt and the synchronised request must all be present at the same edge. Because the request takes two edges to cross the synchroniser, the bench raises rmw_i, berr_i, halt_i and breq_i together and holds them steady across the synchroniser latency. The first edge that sees the request then has no competing acknowledge and no completed cycle. The same combination is then repeated after a cyc_end_i pulse, to show that it is ignored.

// File: rtl/bac_pkg.sv
package bac_pkg;
    localparam int unsigned ST_COUNT = 7;
    localparam int unsigned ST_W     = $clog2(ST_COUNT);

    typedef enum logic [ST_W-1:0] {
        ST_OWN      = 3'd0,
        ST_GRANT    = 3'd1,
        ST_DRAIN    = 3'd2,
        ST_QUIET    = 3'd3,
        ST_RELEASED = 3'd4,
        ST_REGRANT  = 3'd5,
        ST_FORCE    = 3'd6
    } arb_state_t;
endpackage

// File: rtl/bac_sync.sv
module bac_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[LAST];
endmodule

// File: rtl/bac_lock_track.sv
module bac_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rmw_i,
    input  logic cyc_end_i,
    output logic in_first_o,
    output logic lock_past_o
);
    logic past_first_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                 past_first_q <= 1'b0;
        else if (!rmw_i)            past_first_q <= 1'b0;
        else if (cyc_end_i)         past_first_q <= 1'b1;
    end

    assign in_first_o  = rmw_i && !past_first_q;
    assign lock_past_o = rmw_i &&  past_first_q;
endmodule

// File: rtl/bac_fsm.sv
module bac_fsm
    import bac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ack_s,
    input  logic strobe_n,
    input  logic in_first,
    input  logic lock_past,
    input  logic berr,
    input  logic halt,
    output logic grant_o,
    output logic float_o,
    output logic retry_o
);
    arb_state_t cur_q, nxt;
    logic       float_tail_q;
    logic       force_hit;

    assign force_hit = in_first && berr && halt && req_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q        <= ST_OWN;
            float_tail_q <= 1'b0;
        end else begin
            cur_q        <= nxt;
            float_tail_q <= (cur_q == ST_RELEASED) || (cur_q == ST_REGRANT);
        end
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_OWN: begin
                if (lock_past)      nxt = ST_OWN;
                else if (ack_s)     nxt = ST_RELEASED;
                else if (force_hit) nxt = ST_FORCE;
                else if (req_s)     nxt = ST_GRANT;
            end
            ST_FORCE:               nxt = ST_GRANT;
            ST_GRANT: begin
                if (lock_past)      nxt = ST_OWN;
                else if (ack_s)     nxt = ST_DRAIN;
                else if (!req_s)    nxt = ST_OWN;
            end
            ST_DRAIN: begin
                if (!ack_s)         nxt = ST_OWN;
                else if (strobe_n)  nxt = ST_QUIET;
            end
            ST_QUIET: begin
                if (!ack_s)         nxt = ST_OWN;
                else if (strobe_n)  nxt = ST_RELEASED;
                else                nxt = ST_DRAIN;
            end
            ST_RELEASED: begin
                if (!ack_s)                   nxt = ST_OWN;
                else if (req_s && !lock_past) nxt = ST_REGRANT;
            end
            ST_REGRANT: begin
                if (!ack_s)         nxt = ST_OWN;
                else if (!req_s)    nxt = ST_RELEASED;
            end
            default:                nxt = ST_OWN;
        endcase
    end

    always_comb begin
        grant_o = 1'b0;
        retry_o = 1'b0;
        float_o = float_tail_q;
        unique case (cur_q)
            ST_GRANT:    grant_o = 1'b1;
            ST_FORCE: begin
                grant_o = 1'b1;
                retry_o = 1'b1;
            end
            ST_RELEASED: float_o = 1'b1;
            ST_REGRANT: begin
                grant_o = 1'b1;
                float_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic breq_i,
    input  logic back_i,
    input  logic strobe_n_i,
    input  logic rmw_i,
    input  logic cyc_end_i,
    input  logic berr_i,
    input  logic halt_i,
    output logic grant_o,
    output logic float_o,
    output logic retry_o
);
    localparam int unsigned SYNC_W = 2;

    logic [SYNC_W-1:0] async_in, sync_out;
    logic req_s, ack_s;
    logic in_first, lock_past;

    assign async_in = {back_i, breq_i};
    assign req_s    = sync_out[0];
    assign ack_s    = sync_out[1];

    bac_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (async_in),
        .q_o   (sync_out)
    );

    bac_lock_track u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .rmw_i       (rmw_i),
        .cyc_end_i   (cyc_end_i),
        .in_first_o  (in_first),
        .lock_past_o (lock_past)
    );

    bac_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s     (req_s),
        .ack_s     (ack_s),
        .strobe_n  (strobe_n_i),
        .in_first  (in_first),
        .lock_past (lock_past),
        .berr      (berr_i),
        .halt      (halt_i),
        .grant_o   (grant_o),
        .float_o   (float_o),
        .retry_o   (retry_o)
    );
endmodule

// File: rtl/bac_checks.sv
module bac_checks (
    input logic clk,
    input logic rst_n,
    input logic ack_s,
    input logic in_first,
    input logic lock_past,
    input logic grant_o,
    input logic float_o,
    input logic retry_o
);
    AST_LOCK_NO_NEW_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> !$past(lock_past)); // R9

    AST_FLOAT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(float_o) |=> float_o); // R6

    AST_FLOAT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(float_o) |-> $past(ack_s)); // R5

    AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |=> !retry_o); // R11

    AST_RETRY_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> ($past(in_first) && grant_o)); // R11
endmodule

bind bus_arb_ctrl bac_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_s     (ack_s),
    .in_first  (in_first),
    .lock_past (lock_past),
    .grant_o   (grant_o),
    .float_o   (float_o),
    .retry_o   (retry_o)
);

// File: tb/sim_bus_arb_ctrl.sv
module sim_bus_arb_ctrl;
    logic clk = 1'b0;
    logic rst_n, breq, back, strobe_n, rmw, cyc_end, berr, halt;
    logic grant, flt, retry;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    bus_arb_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .breq_i(breq), .back_i(back),
        .strobe_n_i(strobe_n), .rmw_i(rmw), .cyc_end_i(cyc_end),
        .berr_i(berr), .halt_i(halt),
        .grant_o(grant), .float_o(flt), .retry_o(retry)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; breq = 0; back = 0; strobe_n = 1; rmw = 0;
        cyc_end = 0; berr = 0; halt = 0;
        tick(4);
        chk("R1 grant after reset", grant, 1'b0);
        chk("R1 float after reset", flt, 1'b0);
        chk("R1 retry after reset", retry, 1'b0);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_handoff;
        breq = 1;
        tick(2);
        chk("R2 grant not before sync", grant, 1'b0);
        tick(1);
        chk("R2 grant after sync", grant, 1'b1);
        strobe_n = 0; back = 1; breq = 0;
        tick(2);
        chk("R3 grant held until ack acted on", grant, 1'b1);
        tick(1);
        chk("R3 grant drops on ack", grant, 1'b0);
        tick(3);
        chk("R4 no float while strobe busy", flt, 1'b0);
        strobe_n = 1;
        tick(1);
        chk("R4 one idle edge not enough", flt, 1'b0);
        strobe_n = 0;
        tick(1);
        strobe_n = 1;
        tick(1);
        chk("R4 count restarted", flt, 1'b0);
        tick(1);
        chk("R4 float after two idle edges", flt, 1'b1);
        tick(5);
        chk("R5 float held while ack", flt, 1'b1);
        chk("R5 grant low while released", grant, 1'b0);
        breq = 1;
        tick(3);
        chk("R7 regrant grant", grant, 1'b1);
        chk("R7 regrant keeps float", flt, 1'b1);
        breq = 0;
        tick(3);
        chk("R7 back to released grant", grant, 1'b0);
        chk("R7 back to released float", flt, 1'b1);
        back = 0;
        tick(3);
        chk("R6 float tail cycle", flt, 1'b1);
        tick(1);
        chk("R6 float drops after tail", flt, 1'b0);
        tick(2);
    endtask

    task automatic t_single_wire;
        back = 1;
        tick(2);
        chk("R8 float not before sync", flt, 1'b0);
        tick(1);
        chk("R8 ack alone floats bus", flt, 1'b1);
        chk("R8 no grant on ack alone", grant, 1'b0);
        back = 0;
        tick(5);
        chk("R8 float clear after release", flt, 1'b0);
    endtask

    task automatic t_lock_past;
        rmw = 1; cyc_end = 1;
        tick(1);
        cyc_end = 0;
        breq = 1; berr = 1; halt = 1;
        tick(6);
        chk("R9 request ignored past first read", grant, 1'b0);
        chk("R11 no retry past first read", retry, 1'b0);
        berr = 0; halt = 0;
        back = 1; breq = 0;
        tick(4);
        chk("R9 lone ack ignored past first read", flt, 1'b0);
        back = 0; breq = 1;
        tick(4);
        rmw = 0;
        tick(1);
        chk("R9 pending request granted after lock", grant, 1'b1);
        breq = 0;
        tick(3);
        chk("R12 withdrawn request drops grant", grant, 1'b0);
        tick(2);
    endtask

    task automatic t_first_read;
        rmw = 1; breq = 1;
        tick(3);
        chk("R10 grant during first read", grant, 1'b1);
        cyc_end = 1;
        tick(1);
        cyc_end = 0;
        chk("R9 grant until flag is seen", grant, 1'b1);
        tick(1);
        chk("R9 grant withdrawn past first read", grant, 1'b0);
        breq = 0; rmw = 0;
        tick(6);
        chk("R12 idle after cleanup", grant, 1'b0);
    endtask

    task automatic t_force;
        rmw = 1; berr = 1; halt = 1; breq = 1;
        tick(2);
        chk("R11 no retry before sync", retry, 1'b0);
        tick(1);
        chk("R11 retry pulse", retry, 1'b1);
        chk("R11 grant in force", grant, 1'b1);
        tick(1);
        chk("R11 retry one cycle", retry, 1'b0);
        chk("R11 grant after force", grant, 1'b1);
        berr = 0; halt = 0; breq = 0; rmw = 0;
        tick(4);
        chk("R11 idle after force", grant, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_handoff();
        t_single_wire();
        t_lock_past();
        t_first_read();
        t_force();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule